// File: doc/BRIEF.md
# APB GPIO Port Register File

This block is the register front end of a 32-pin general-purpose I/O controller that sits on an APB slave port. Software picks each pin's direction and output level, and it reads back the pin levels after a two-flop synchroniser has resampled them. The direction and output-value buses go straight to the pad ring. The synchronised pin levels also go out to a companion interrupt unit.

Output bits can be changed in three ways. The output data word can be written whole. A write-one-to-set word raises only the bits written as 1. A write-one-to-clear word lowers only the bits written as 1. With the set and clear words, software never has to read, modify and write back a shared word. The block also stores three plain configuration words: a control word, a per-pin debounce-enable word for an external filter, and a filter configuration word. Each is brought out as a bus. The interrupt registers live at their own word offsets in the same 16-word window and are decoded by the companion unit. This block returns zero for them and stores nothing for them.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, every word in the 16-word window reads 0 (with the pins held low), all pins are inputs (`gpio_oe_o` = 0), and `gpio_out_o` = 0.
- R2: The word at byte offset 0x00 is the direction word and can be read and written. A 1 in bit n drives `gpio_oe_o[n]` high, which makes pin n an output, and a 0 makes pin n an input.
- R3: The word at 0x10 is the output data word and can be read and written. Its value appears on `gpio_out_o` from the cycle after the write.
- R4: A write to 0x08 sets the output data bits that are written as 1 and leaves the bits written as 0 unchanged.
- R5: A write to 0x0C clears the output data bits that are written as 1 and leaves the bits written as 0 unchanged.
- R6: Reads of 0x08 and 0x0C always return 0.
- R7: A read of 0x14 returns the pin levels as sampled through a two-flop synchroniser. A write to 0x14 changes no register.
- R8: The words at 0x04 (control), 0x38 (debounce enable) and 0x3C (filter configuration) can be read and written. Their contents appear on `ctrl_o`, `dbnc_en_o` and `cfg_o` respectively.
- R9: Word offsets 0x18 through 0x34, and every address above 0x3C, read 0 from this block. Writes to them change no register.
- R10: `pready` is always 1 and `pslverr` is always 0.
- R11: `pin_sync_o` equals `pin_i` delayed by exactly two clock edges.
- R12: A write takes effect only in the APB access phase (`psel` and `penable` both high). A setup phase with no access phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| preset_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | Byte address; bits [1:0] ignored |
| pwdata | input | NPIN | Write data |
| prdata | output | NPIN | Read data; 0 outside a read access |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pin_i | input | NPIN | Asynchronous pin levels from the pads |
| pin_sync_o | output | NPIN | Synchronised pin levels for the interrupt unit |
| gpio_oe_o | output | NPIN | Per-pin output enable to the pads |
| gpio_out_o | output | NPIN | Per-pin output value to the pads |
| dbnc_en_o | output | NPIN | Per-pin debounce enable to the filter |
| ctrl_o | output | NPIN | Control word contents |
| cfg_o | output | NPIN | Filter configuration word contents |

## Verification
The hardest case to reach is a set or clear write that lands on an output word that already holds a mix of ones and zeros. Only a mixed prior value shows that the bits written as 0 really are left alone. The random stimulus interleaves whole-word writes, set writes and clear writes with random data to the same word, so every set or clear meets an arbitrary prior pattern. The bench then compares `gpio_out_o` against its own model after every write. Pin changes are followed by two idle cycles before the input word is read, so the synchroniser delay is exercised. A directed setup-phase-only write checks that an access without `penable` changes nothing.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the GPIO port register file: the size of the
// register window and the word indices that the decoder and read mux use.
package gpio_port_pkg;

    localparam int unsigned NWORDS = 16;
    localparam int unsigned IDX_W  = $clog2(NWORDS);

    // Word index = byte offset / 4. Offsets 6..13 belong to the interrupt unit.
    typedef enum logic [IDX_W-1:0] {
        RG_DIR  = 4'd0,
        RG_CTRL = 4'd1,
        RG_SET  = 4'd2,
        RG_CLR  = 4'd3,
        RG_OUT  = 4'd4,
        RG_IN   = 4'd5,
        RG_DBNC = 4'd14,
        RG_CFG  = 4'd15
    } reg_idx_e;

endpackage

// File: rtl/gpio_port_decode.sv
// APB address decoder.
// Produces one write strobe per word of the 16-word window, plus a
// read-active flag and the word index for the read mux.
// Assumes ADDR_W > 6 so that address bits above the window exist; any
// such bit set puts the access outside the map.
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    output logic [NWORDS-1:0]    wr_stb,
    output logic                 rd_act,
    output logic [IDX_W-1:0]     word_idx
);

    localparam int unsigned LO_B = 2;
    localparam int unsigned HI_B = LO_B + IDX_W;

    logic in_map;
    logic access;
    logic unused_byte_lane;

    assign unused_byte_lane = ^paddr[LO_B-1:0];
    assign word_idx = paddr[HI_B-1:LO_B];
    assign in_map   = (paddr[ADDR_W-1:HI_B] == '0);
    assign access   = psel & penable;
    assign rd_act   = access & ~pwrite & in_map;

    // One strobe per word; only the access phase of a write may fire one.
    for (genvar i = 0; i < NWORDS; i++) begin : g_stb
        assign wr_stb[i] = access & pwrite & in_map & (word_idx == i[IDX_W-1:0]);
    end

endmodule

// File: rtl/gpio_port_sync.sv
// Multi-flop synchroniser for the pin inputs.
// Every bit is resampled through STAGES flops; the bits are independent,
// so no bus coherency is implied. Reset clears all stages.
module gpio_port_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [STAGES-1:0][W-1:0] stg;
    logic [1:0]               live_cnt;

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

    // Count active edges since reset (saturating) so the check below only
    // looks back over cycles in which the chain was running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    // R11
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && live_cnt >= 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_port_outreg.sv
// Direction and output data registers.
// The output word accepts a whole-word write, a write-one-to-set or a
// write-one-to-clear; the decoder guarantees at most one strobe per cycle.
module gpio_port_outreg #(
    parameter int unsigned W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  wdata,
    input  logic          wr_dir,
    input  logic          wr_out,
    input  logic          wr_set,
    input  logic          wr_clr,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  out_q
);

    // Direction word: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    // Output word: whole load, bit set or bit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_out) begin
            out_q <= wdata;
        end else if (wr_set) begin
            out_q <= out_q | wdata;
        end else if (wr_clr) begin
            out_q <= out_q & ~wdata;
        end
    end

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_out || wr_set || wr_clr) |=> $stable(out_q));

endmodule

// File: rtl/gpio_port_rwreg.sv
// Plain read/write storage word with synchronous active-low reset.
module gpio_port_rwreg #(
    parameter int unsigned W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);

    // Load on write strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_port.sv
// GPIO port register file on an APB slave.
// Holds direction, output data (with set/clear aliases), control,
// debounce-enable and filter configuration words, and returns the
// synchronised pin levels. Interrupt word offsets are left to a companion
// unit and read 0 here. No wait states, no error responses.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic               pclk,
    input  logic               preset_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [NPIN-1:0]    pwdata,
    output logic [NPIN-1:0]    prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NPIN-1:0]    pin_i,
    output logic [NPIN-1:0]    pin_sync_o,
    output logic [NPIN-1:0]    gpio_oe_o,
    output logic [NPIN-1:0]    gpio_out_o,
    output logic [NPIN-1:0]    dbnc_en_o,
    output logic [NPIN-1:0]    ctrl_o,
    output logic [NPIN-1:0]    cfg_o
);

    localparam int unsigned NCFG = 3;

    logic [NWORDS-1:0] wr_stb;
    logic              rd_act;
    logic [IDX_W-1:0]  word_idx;
    logic [NCFG-1:0]   cfg_we;
    logic [NPIN-1:0]   cfg_q [NCFG];

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .wr_stb   (wr_stb),
        .rd_act   (rd_act),
        .word_idx (word_idx)
    );

    gpio_port_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk   (pclk),
        .rst_n (preset_n),
        .din   (pin_i),
        .dout  (pin_sync_o)
    );

    gpio_port_outreg #(.W(NPIN)) u_outreg (
        .clk    (pclk),
        .rst_n  (preset_n),
        .wdata  (pwdata),
        .wr_dir (wr_stb[RG_DIR]),
        .wr_out (wr_stb[RG_OUT]),
        .wr_set (wr_stb[RG_SET]),
        .wr_clr (wr_stb[RG_CLR]),
        .dir_q  (gpio_oe_o),
        .out_q  (gpio_out_o)
    );

    // Storage-only words: 0 = control, 1 = debounce enable, 2 = filter config.
    assign cfg_we[0] = wr_stb[RG_CTRL];
    assign cfg_we[1] = wr_stb[RG_DBNC];
    assign cfg_we[2] = wr_stb[RG_CFG];

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        gpio_port_rwreg #(.W(NPIN)) u_word (
            .clk   (pclk),
            .rst_n (preset_n),
            .we    (cfg_we[k]),
            .wdata (pwdata),
            .q     (cfg_q[k])
        );
    end

    assign ctrl_o    = cfg_q[0];
    assign dbnc_en_o = cfg_q[1];
    assign cfg_o     = cfg_q[2];

    // Read mux: zero unless a read access is in progress.
    always_comb begin
        prdata = '0;
        if (rd_act) begin
            case (word_idx)
                RG_DIR:  prdata = gpio_oe_o;
                RG_CTRL: prdata = cfg_q[0];
                RG_OUT:  prdata = gpio_out_o;
                RG_IN:   prdata = pin_sync_o;
                RG_DBNC: prdata = cfg_q[1];
                RG_CFG:  prdata = cfg_q[2];
                default: prdata = '0;
            endcase
        end
    end

    // R4
    set_rise_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        wr_stb[RG_SET] |=> ((gpio_out_o & $past(pwdata)) == $past(pwdata)));

    // R4
    set_keep_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        wr_stb[RG_SET] |=> ((gpio_out_o & ~$past(pwdata)) == ($past(gpio_out_o) & ~$past(pwdata))));

    // R5
    clr_fall_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        wr_stb[RG_CLR] |=> ((gpio_out_o & $past(pwdata)) == '0));

    // R5
    clr_keep_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        wr_stb[RG_CLR] |=> ((gpio_out_o | $past(pwdata)) == ($past(gpio_out_o) | $past(pwdata))));

    // R6
    alias_zero_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && penable && !pwrite && (paddr == ADDR_W'(8)  || paddr == ADDR_W'(12)))
        |-> (prdata == '0));

    // R12
    setup_quiet_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && !penable) |=> ($stable(gpio_oe_o) && $stable(dbnc_en_o) && $stable(cfg_o)));

endmodule

// File: tb/gpio_port_tb.sv
// Self-checking bench: random register traffic against a bench model,
// plus directed reset, setup-only and out-of-map cases.
module gpio_port_tb;

    localparam int NPIN   = 32;
    localparam int ADDR_W = 8;

    logic              pclk = 1'b0;
    logic              preset_n;
    logic              psel, penable, pwrite;
    logic [ADDR_W-1:0] paddr;
    logic [NPIN-1:0]   pwdata, prdata, pin_i;
    logic              pready, pslverr;
    logic [NPIN-1:0]   pin_sync_o, gpio_oe_o, gpio_out_o, dbnc_en_o, ctrl_o, cfg_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // bench model
    logic [NPIN-1:0] m_dir, m_out, m_ctrl, m_db, m_cfg, m_pin;

    always #5 pclk = ~pclk;

    gpio_port #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dut (
        .pclk(pclk), .preset_n(preset_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pin_i(pin_i),
        .pin_sync_o(pin_sync_o), .gpio_oe_o(gpio_oe_o), .gpio_out_o(gpio_out_o),
        .dbnc_en_o(dbnc_en_o), .ctrl_o(ctrl_o), .cfg_o(cfg_o)
    );

    task automatic chk(input string req, input logic [NPIN-1:0] got, input logic [NPIN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    // Expected read value for a byte address.
    function automatic logic [NPIN-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:6] != '0) return '0;
        case (a[5:2])
            4'd0:  return m_dir;
            4'd1:  return m_ctrl;
            4'd4:  return m_out;
            4'd5:  return m_pin;
            4'd14: return m_db;
            4'd15: return m_cfg;
            default: return '0;
        endcase
    endfunction

    function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] d);
        if (a[ADDR_W-1:6] != '0) return;
        case (a[5:2])
            4'd0:  m_dir  = d;
            4'd1:  m_ctrl = d;
            4'd2:  m_out  = m_out | d;
            4'd3:  m_out  = m_out & ~d;
            4'd4:  m_out  = d;
            4'd14: m_db   = d;
            4'd15: m_cfg  = d;
            default: ;
        endcase
    endfunction

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        model_write(a, d);
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [NPIN-1:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1;
        d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " oe"},   gpio_oe_o,  m_dir);
        chk({req, " out"},  gpio_out_o, m_out);
        chk({req, " dbnc"}, dbnc_en_o,  m_db);
        chk({req, " ctrl"}, ctrl_o,     m_ctrl);
        chk({req, " cfg"},  cfg_o,      m_cfg);
    endtask

    task automatic set_pins(input logic [NPIN-1:0] p);
        @(negedge pclk);
        pin_i = p;
        m_pin = p;
        repeat (2) @(negedge pclk);
        chk("R11 pin_sync", pin_sync_o, m_pin);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NPIN-1:0] rd;
        void'($urandom(32'd20250407));
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pin_i = '0;
        m_dir = '0; m_out = '0; m_ctrl = '0; m_db = '0; m_cfg = '0; m_pin = '0;
        preset_n = 0;
        repeat (4) @(negedge pclk);
        preset_n = 1;

        // R1: reset state on ports and every word of the window
        chk_outputs("R1");
        for (int w = 0; w < 16; w++) begin
            apb_read(ADDR_W'(w * 4), rd);
            chk("R1 reset read", rd, '0);
        end
        // R10
        chk("R10 pready", {{(NPIN-1){1'b0}}, pready}, 32'd1);
        chk("R10 pslverr", {{(NPIN-1){1'b0}}, pslverr}, 32'd0);

        // R2 / R3 directed
        apb_write(8'h00, 32'hA5A5_0F0F);
        chk_outputs("R2");
        apb_write(8'h10, 32'h1234_5678);
        chk_outputs("R3");
        // R4 / R5 on a mixed prior pattern
        apb_write(8'h08, 32'h0000_FFFF);
        chk_outputs("R4");
        apb_write(8'h0C, 32'hFF00_00F0);
        chk_outputs("R5");
        apb_read(8'h08, rd); chk("R6 set reads 0", rd, '0);
        apb_read(8'h0C, rd); chk("R6 clr reads 0", rd, '0);

        // R7: pin levels through synchroniser; write to input word ignored
        set_pins(32'hDEAD_BEEF);
        apb_read(8'h14, rd); chk("R7 idata", rd, m_pin);
        apb_write(8'h14, 32'h0000_0000);
        chk_outputs("R7 idata write");
        apb_read(8'h14, rd); chk("R7 idata after write", rd, m_pin);

        // R8 storage words
        apb_write(8'h04, 32'h0000_00C3);
        apb_write(8'h38, 32'h8000_0001);
        apb_write(8'h3C, 32'h0F0F_F0F0);
        chk_outputs("R8");

        // R9: interrupt offsets and beyond the window
        for (int w = 6; w < 14; w++) begin
            apb_write(ADDR_W'(w * 4), 32'hFFFF_FFFF);
            chk_outputs("R9 write");
            apb_read(ADDR_W'(w * 4), rd);
            chk("R9 read", rd, '0);
        end
        apb_write(8'h40, 32'hFFFF_FFFF);
        chk_outputs("R9 above map");
        apb_read(8'h40, rd); chk("R9 above map read", rd, '0);

        // R12: setup phase only, never an access phase
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = 8'h00; pwdata = ~m_dir;
        repeat (3) @(negedge pclk);
        psel = 0; pwrite = 0;
        chk_outputs("R12 setup only");
        apb_read(8'h00, rd); chk("R12 dir unchanged", rd, m_dir);

        // Random traffic
        for (int i = 0; i < 700; i++) begin
            logic [ADDR_W-1:0] a;
            logic [NPIN-1:0]   d;
            int unsigned       sel;
            sel = $urandom % 8;
            if (sel == 0) a = ADDR_W'(($urandom % 4) * 4) | 8'h40;
            else if (sel < 4) a = ADDR_W'((2 + ($urandom % 3)) * 4);
            else a = ADDR_W'(($urandom % 16) * 4);
            d = $urandom;
            if (($urandom % 6) == 0) set_pins($urandom);
            if ($urandom % 2) begin
                apb_write(a, d);
                chk_outputs("R3 R4 R5 random write");
            end else begin
                apb_read(a, rd);
                chk("R2 R6 R7 R8 R9 random read", rd, exp_read(a));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule